// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in first-out store of 64 words held in registers and addressed by a 6-bit stack pointer. A push request takes the word on the write-data input and places it on top of the stack. A pop request copies the top word into an output data register. Two status outputs report whether the stack is full or empty.

The pointer counts up on a push and down on a pop, and it wraps modulo 64. A push advances the pointer before it writes, and a pop reads before it steps back. Location 0 is therefore the last slot to be filled. Both flags come from the pointer returning to zero; there is no separate occupancy count. A request that cannot be served is dropped, and a one-cycle error pulse reports it.

Top module: `lifo_reg_stack`

## Requirements
- R1: The stack holds 2**PTR_W words (64 by default) and the pointer is PTR_W bits wide (6 by default). Exactly 64 pushes from empty are accepted before full_o rises.
- R2: After reset the pointer is 0, empty_o is 1, full_o is 0, err_o is 0 and rd_data_o is 0.
- R3: An accepted push (push_i=1, pop_i=0, full_o=0) first increments the pointer, then writes wr_data_i at the new pointer address. empty_o is 0 after the clock edge.
- R4: When the increment of an accepted push wraps the pointer to 0, full_o is 1 after that edge.
- R5: An accepted pop (pop_i=1, push_i=0, empty_o=0) reads the word at the current pointer and then decrements the pointer. full_o is 0 after the edge. Words come back in the reverse order of their pushes.
- R6: When the decrement of an accepted pop brings the pointer to 0, empty_o is 1 after that edge.
- R7: A push while full_o=1, or a pop while empty_o=1, changes neither the pointer, the stored words, the flags nor rd_data_o. err_o is 1 for exactly the one cycle after such a request.
- R8: If push_i and pop_i are both 1 in the same cycle, nothing changes and err_o stays 0.
- R9: rd_data_o takes the popped word on the clock edge that accepts the pop. It holds its value in every cycle without an accepted pop.
- R10: The data width is the parameter DATA_W, with a default of 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wr_data_i | input | DATA_W | Word to push |
| rd_data_o | output | DATA_W | Registered popped word |
| full_o | output | 1 | Stack full flag |
| empty_o | output | 1 | Stack empty flag |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
On every cycle the assertions check the following:
- the pointer steps by one in the right direction on each accepted request;
- each flag is high only while the pointer is zero, and the two flags are never high together;
- rejected and simultaneous requests leave the pointer and the output register unchanged, with the error pulse high only after a rejection;
- the output register holds its value when no pop is accepted.

Only the bench scenarios can show that the stored words come back in reverse push order across a full 64-entry fill and drain. They also show that slot 0 really holds the last word pushed, and that a push rejected while full leaves the top word intact.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_REJECT
    } stack_op_e;

    function automatic stack_op_e classify_req(
        input logic push,
        input logic pop,
        input logic full,
        input logic empty
    );
        stack_op_e op;
        op = OP_IDLE;
        if (push && !pop) begin
            op = full ? OP_REJECT : OP_PUSH;
        end else if (pop && !push) begin
            op = empty ? OP_REJECT : OP_POP;
        end
        return op;
    endfunction

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic             rd_en_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             full;
        logic             empty;
        logic             err;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;
    stack_op_e   op;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    always_comb begin
        op      = classify_req(push_i, pop_i, state_q.full, state_q.empty);
        ptr_inc = state_q.ptr + 1'b1;
        ptr_dec = state_q.ptr - 1'b1;
        state_d     = state_q;
        state_d.err = 1'b0;
        wr_en_o     = 1'b0;
        rd_en_o     = 1'b0;
        wr_addr_o   = ptr_inc;
        unique case (op)
            OP_PUSH: begin
                wr_en_o       = 1'b1;
                state_d.ptr   = ptr_inc;
                state_d.empty = 1'b0;
                state_d.full  = (ptr_inc == '0);
            end
            OP_POP: begin
                rd_en_o       = 1'b1;
                state_d.ptr   = ptr_dec;
                state_d.full  = 1'b0;
                state_d.empty = (ptr_dec == '0);
            end
            OP_REJECT: begin
                state_d.err = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{ptr: '0, full: 1'b0, empty: 1'b1, err: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign ptr_o   = state_q.ptr;
    assign full_o  = state_q.full;
    assign empty_o = state_q.empty;
    assign err_o   = state_q.err;

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_word_o
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            slots[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_word_o = slots[rd_addr_i];

endmodule

// File: rtl/lifo_rdreg.sv
module lifo_rdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load_i) begin
            data_d = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/lifo_reg_stack.sv
module lifo_reg_stack #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);

    logic [PTR_W-1:0]  stk_ptr;
    logic [PTR_W-1:0]  wr_addr;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] top_word;

    lifo_ctrl #(.PTR_W(PTR_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .ptr_o     (stk_ptr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .rd_en_o   (rd_en),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o)
    );

    lifo_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data_i),
        .rd_addr_i (stk_ptr),
        .rd_word_o (top_word)
    );

    lifo_rdreg #(.DATA_W(DATA_W)) i_rdreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rd_en),
        .word_i (top_word),
        .data_o (rd_data_o)
    );

endmodule

// File: rtl/lifo_reg_stack_chk.sv
module lifo_reg_stack_chk #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              full_o,
    input logic              empty_o,
    input logic              err_o,
    input logic [PTR_W-1:0]  ptr
);

    logic [PTR_W-1:0] ptr_plus, ptr_minus;
    logic push_ok, pop_ok, rejected, both;

    assign ptr_plus  = ptr + 1'b1;
    assign ptr_minus = ptr - 1'b1;
    assign push_ok   = push_i && !pop_i && !full_o;
    assign pop_ok    = pop_i && !push_i && !empty_o;
    assign rejected  = (push_i && !pop_i && full_o) || (pop_i && !push_i && empty_o);
    assign both      = push_i && pop_i;

    assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (ptr == $past(ptr_plus)) && !empty_o);

    assert_full_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (ptr == '0));

    assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> (ptr == $past(ptr_minus)) && !full_o);

    assert_empty_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (ptr == '0) && !full_o);

    assert_reject_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |=> err_o && $stable(ptr) && $stable(full_o) && $stable(empty_o));

    assert_err_only_after_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rejected |=> !err_o);

    assert_both_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        both |=> $stable(ptr) && $stable(rd_data_o) && !err_o);

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_ok |=> $stable(rd_data_o));

endmodule

bind lifo_reg_stack lifo_reg_stack_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .rd_data_o (rd_data_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o),
    .ptr       (stk_ptr)
);

// File: tb/test_lifo_reg_stack.sv
module test_lifo_reg_stack;

    localparam int DW    = 8;
    localparam int PW    = 6;
    localparam int DEPTH = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          full, empty, err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference state, derived from the requirements
    logic [DW-1:0] m_mem [DEPTH];
    logic [PW-1:0] m_ptr = '0;
    logic          m_full = 1'b0;
    logic          m_empty = 1'b1;
    logic          m_err = 1'b0;
    logic [DW-1:0] m_rd = '0;

    always #2 clk = ~clk;

    lifo_reg_stack #(.DATA_W(DW), .PTR_W(PW)) i_lifo_reg_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .pop_i     (pop),
        .wr_data_i (wdata),
        .rd_data_o (rd_data),
        .full_o    (full),
        .empty_o   (empty),
        .err_o     (err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " full"},  int'(full),    int'(m_full));
        check({tag, " empty"}, int'(empty),   int'(m_empty));
        check({tag, " err"},   int'(err),     int'(m_err));
        check({tag, " data"},  int'(rd_data), int'(m_rd));
    endtask

    task automatic step(input logic pu, input logic po, input logic [DW-1:0] d);
        @(negedge clk);
        push = pu; pop = po; wdata = d;
        m_err = 1'b0;
        if (pu && !po) begin
            if (m_full) m_err = 1'b1;
            else begin
                m_ptr = m_ptr + 1'b1;
                m_mem[m_ptr] = d;
                m_empty = 1'b0;
                m_full = (m_ptr == '0);
            end
        end else if (po && !pu) begin
            if (m_empty) m_err = 1'b1;
            else begin
                m_rd = m_mem[m_ptr];
                m_ptr = m_ptr - 1'b1;
                m_full = 1'b0;
                m_empty = (m_ptr == '0);
            end
        end
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R2 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R6 R7: pop on an empty stack is rejected
        step(1'b0, 1'b1, 8'h00);
        check_all("R7 pop while empty");
        step(1'b0, 1'b0, 8'h00);
        check_all("R7 err one cycle");

        // R1 R3 R4: fill all 64 slots, full only on the last push
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, DW'((i * 37 + 5) % 256));
            check_all(i == DEPTH - 1 ? "R4 full on wrap" : "R3 push");
        end
        check("R1 full after 64", int'(full), 1);

        // R7: a push while full must not touch the top word
        step(1'b1, 1'b0, 8'hEE);
        check_all("R7 push while full");
        // R8: simultaneous requests do nothing
        step(1'b1, 1'b1, 8'h11);
        check_all("R8 both while full");

        // R5 R6 R9: drain in reverse order
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(1'b0, 1'b1, 8'h00);
            check("R5 lifo order", int'(rd_data), (i * 37 + 5) % 256);
            check_all(i == 0 ? "R6 empty on last pop" : "R5 pop");
            step(1'b0, 1'b0, 8'h00);
            check_all("R9 data hold");
        end
        step(1'b0, 1'b1, 8'h00);
        check_all("R7 pop after drain");

        // R8 R3 R5: interleaved pattern with simultaneous requests mixed in
        for (int i = 0; i < 200; i++) begin
            logic pu, po;
            pu = ((i * 7) % 5) < 3;
            po = ((i * 3) % 4) == 1;
            step(pu, po, DW'((i * 91 + 13) % 256));
            check_all(pu && po ? "R8 both" : (pu ? "R3 mix push" : "R5 mix pop"));
        end

        // R10: a full data-width value survives a round trip
        step(1'b1, 1'b0, 8'hFF);
        check_all("R10 push wide");
        step(1'b0, 1'b1, 8'h00);
        check("R10 data width", int'(rd_data), 255);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule